// File: doc/BRIEF.md
# Data Memory Overlay Address Decoder

This block sits between a processor core's data-memory port and three possible targets. It classifies each 14-bit data address. The upper half of the space always stays on chip. Most of that half is general RAM, and the topmost 32 words form a bank of control registers. The lower half is sent to an external bus, into one of two overlay pages picked by a 2-bit page-select input.

When the access goes off chip, the decoder builds the external address itself. The 13 low address bits pass straight through. The top external address bit is not the core's bit 13: it is derived from the page number. An external access raises a flag that a separate wait-state unit watches. The decoder then holds the access, with stable address, strobes and write data, until that unit returns ready. On-chip accesses finish without any stall.

The core issues a one-cycle request pulse while `core_busy` is low. A single-cycle `core_ack` pulse reports completion, together with the read data and a code naming the target that served the access.

Top module: `dmo_decoder`

## Requirements
- R1: A request to 0x2000–0x3FDF is served by on-chip RAM and reports target code 1. A write followed by a read of the same address returns the written word. The RAM holds 2^RAM_AW words, and the low RAM_AW address bits select the word.
- R2: A request to 0x3FE0–0x3FFF is served by the control-register bank at index addr[4:0] and reports target code 2.
- R3: A request to 0x0000–0x1FFF with page select 1 starts an external cycle. It reports target code 3, drives ext_addr[13]=0 and drives ext_addr[12:0] equal to the core address bits [12:0].
- R4: The same request with page select 2 drives ext_addr[13]=1. The other fields are as in R3.
- R5: A lower-half request with page select 0 or 3 raises no external strobe. It completes like an on-chip access with target code 0 and read data 0, and a write is dropped.
- R6: An on-chip or reserved-page request accepted at a clock edge raises core_ack for exactly the following cycle, and core_busy stays low.
- R7: During an external cycle, ext_active, ext_addr (including bit 13) and the strobes hold steady until ext_ready is sampled high. A change of page select after acceptance does not alter ext_addr[13].
- R8: ext_ready sampled high during an external cycle ends it at that edge. core_ack rises for the next cycle and carries ext_rdata.
- R9: Control registers reset to 0. Even indices keep all 16 bits. Odd indices keep bits [7:0] only, and their bits [15:8] read 0 whatever was written.
- R10: A request raised while core_busy is high is ignored: it writes nothing and produces no extra acknowledge.
- R11: After reset, core_ack, core_busy and ext_active are 0, and core_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | One-cycle access request |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_addr | input | 14 | Data address |
| core_wdata | input | 16 | Write data |
| ovl_page | input | 2 | Overlay page select |
| core_ack | output | 1 | Access complete, one cycle |
| core_rdata | output | 16 | Read data, valid with core_ack |
| core_busy | output | 1 | External cycle in progress |
| acc_target | output | 2 | 0 none, 1 RAM, 2 registers, 3 external; valid with core_ack |
| ext_active | output | 1 | External-access flag for the wait-state unit |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 14 | External address, bit 13 from the page |
| ext_wdata | output | 16 | External write data |
| ext_ready | input | 1 | Wait-state unit releases the cycle |
| ext_rdata | input | 16 | External read data |

## Verification
Two functions can meet in one cycle. The first is a held external cycle, which must keep its address and page bit. The second is a fresh core request, or a change of page select, arriving while that cycle waits. The bench raises a write to an on-chip word while ext_ready is held low and flips the page select in the same window. Afterwards it checks that ext_addr[13] kept its accepted value, that only one acknowledge appears, and that reading the on-chip word back returns its earlier contents.

// File: rtl/dmo_pkg.sv
// Shared types for the data-memory overlay decoder.
// Assumes a 2-bit target code that is visible at the top-level port.
package dmo_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_REG  = 2'd2,
        TGT_EXT  = 2'd3
    } tgt_e;
endpackage

// File: rtl/dmo_region_decode.sv
// Combinational address classifier.
// Upper half: on chip (registers in the top 2^REG_AW words, RAM below them).
// Lower half: external when page is 1 or 2, otherwise no target.
// Assumes AW > REG_AW + 1.
module dmo_region_decode
    import dmo_pkg::*;
#(
    parameter int AW     = 14,
    parameter int REG_AW = 5
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    page,
    output tgt_e          tgt,
    output logic          hi_bit
);
    localparam int HI = AW - 1;

    // Classify the address and derive the synthesized top external bit.
    always_comb begin
        hi_bit = (page == 2'd2);
        if (addr[HI]) begin
            tgt = (&addr[HI:REG_AW]) ? TGT_REG : TGT_RAM;
        end else if (page == 2'd1 || page == 2'd2) begin
            tgt = TGT_EXT;
        end else begin
            tgt = TGT_NONE;
        end
    end
endmodule

// File: rtl/dmo_ram.sv
// Behavioural single-port RAM with a write port and a combinational read port.
// Assumes the caller folds the address into RAM_AW bits.
module dmo_ram #(
    parameter int DW     = 16,
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int WORDS = 1 << RAM_AW;

    logic [DW-1:0] mem [WORDS];

    // Store the write data on an enabled edge.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Present the addressed word.
    always_comb rdata = mem[addr];
endmodule

// File: rtl/dmo_ctrl_regs.sv
// Bank of memory-mapped control registers.
// Even indices implement every bit. Odd indices implement the low half only.
// Unimplemented bits read zero and ignore writes. Synchronous reset to zero.
module dmo_ctrl_regs #(
    parameter int DW     = 16,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int NREG = 1 << REG_AW;
    localparam logic [DW-1:0] FULL = {DW{1'b1}};
    localparam logic [DW-1:0] HALF = {{(DW - DW/2){1'b0}}, {(DW/2){1'b1}}};

    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] MASK = (i % 2 == 0) ? FULL : HALF;
        // Hold one register; only implemented bits take write data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && idx == REG_AW'(i)) begin
                regs[i] <= wdata & MASK;
            end
        end
    end

    // Select the addressed register for reading.
    always_comb rdata = regs[idx];
endmodule

// File: rtl/dmo_ext_seq.sv
// External-cycle sequencer.
// It latches the address, page bit, direction and data when a cycle starts.
// It holds them on the external pins until ready is sampled high.
// Assumes start is only raised while busy is low.
module dmo_ext_seq #(
    parameter int AW = 14,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-2:0] low_addr,
    input  logic          hi_bit,
    input  logic [DW-1:0] wdata,
    input  logic          ready,
    output logic          busy,
    output logic          done,
    output logic          ext_rd,
    output logic          ext_wr,
    output logic [AW-1:0] ext_addr,
    output logic [DW-1:0] ext_wdata
);
    typedef enum logic {S_IDLE = 1'b0, S_EXT = 1'b1} st_e;

    st_e           st;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    // Sequence state: enter on start, leave when ready is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else if (st == S_IDLE && start) begin
            st <= S_EXT;
        end else if (st == S_EXT && ready) begin
            st <= S_IDLE;
        end
    end

    // Capture the access attributes at the start of a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (st == S_IDLE && start) begin
            wr_q    <= wr;
            addr_q  <= {hi_bit, low_addr};
            wdata_q <= wdata;
        end
    end

    // Drive the external pins from the captured state.
    always_comb begin
        busy      = (st == S_EXT);
        done      = (st == S_EXT) && ready;
        ext_rd    = busy && !wr_q;
        ext_wr    = busy && wr_q;
        ext_addr  = busy ? addr_q : '0;
        ext_wdata = (busy && wr_q) ? wdata_q : '0;
    end
endmodule

// File: rtl/dmo_decoder.sv
// Top of the data-memory overlay decoder.
// It accepts one-cycle core requests, routes them to RAM, to the control
// registers or to the external overlay bus, and returns a registered
// acknowledge with read data and a target code.
// Assumes the core raises core_req only while core_busy is low; other
// requests are dropped.
module dmo_decoder
    import dmo_pkg::*;
#(
    parameter int AW     = 14,
    parameter int DW     = 16,
    parameter int REG_AW = 5,
    parameter int RAM_AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_wr,
    input  logic [13:0]   core_addr,
    input  logic [15:0]   core_wdata,
    input  logic [1:0]    ovl_page,
    output logic          core_ack,
    output logic [15:0]   core_rdata,
    output logic          core_busy,
    output logic [1:0]    acc_target,
    output logic          ext_active,
    output logic          ext_rd,
    output logic          ext_wr,
    output logic [13:0]   ext_addr,
    output logic [15:0]   ext_wdata,
    input  logic          ext_ready,
    input  logic [15:0]   ext_rdata
);
    tgt_e          tgt;
    logic          hi_bit;
    logic          accept;
    logic          busy;
    logic          done;
    logic [DW-1:0] ram_rd;
    logic [DW-1:0] reg_rd;
    logic          ack_q;
    logic [DW-1:0] rdata_q;
    tgt_e          tgt_q;

    dmo_region_decode #(.AW(AW), .REG_AW(REG_AW)) u_dec (
        .addr   (core_addr),
        .page   (ovl_page),
        .tgt    (tgt),
        .hi_bit (hi_bit)
    );

    // Take a request only when no external cycle is pending.
    always_comb accept = core_req && !busy;

    dmo_ram #(.DW(DW), .RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (accept && core_wr && tgt == TGT_RAM),
        .addr  (core_addr[RAM_AW-1:0]),
        .wdata (core_wdata),
        .rdata (ram_rd)
    );

    dmo_ctrl_regs #(.DW(DW), .REG_AW(REG_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept && core_wr && tgt == TGT_REG),
        .idx   (core_addr[REG_AW-1:0]),
        .wdata (core_wdata),
        .rdata (reg_rd)
    );

    dmo_ext_seq #(.AW(AW), .DW(DW)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && tgt == TGT_EXT),
        .wr        (core_wr),
        .low_addr  (core_addr[AW-2:0]),
        .hi_bit    (hi_bit),
        .wdata     (core_wdata),
        .ready     (ext_ready),
        .busy      (busy),
        .done      (done),
        .ext_rd    (ext_rd),
        .ext_wr    (ext_wr),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata)
    );

    // Register the completion: immediate for on-chip and reserved, on ready for external.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
            tgt_q   <= TGT_NONE;
        end else begin
            ack_q <= 1'b0;
            if (done) begin
                ack_q   <= 1'b1;
                rdata_q <= ext_rdata;
                tgt_q   <= TGT_EXT;
            end else if (accept && tgt != TGT_EXT) begin
                ack_q   <= 1'b1;
                tgt_q   <= tgt;
                rdata_q <= (core_wr)          ? '0     :
                           (tgt == TGT_RAM)   ? ram_rd :
                           (tgt == TGT_REG)   ? reg_rd : '0;
            end
        end
    end

    // Drive the core-side outputs.
    always_comb begin
        core_ack   = ack_q;
        core_rdata = rdata_q;
        acc_target = tgt_q;
        core_busy  = busy;
        ext_active = busy;
    end
endmodule

// File: rtl/dmo_decoder_chk.sv
// Property checker for dmo_decoder, attached through bind.
module dmo_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        core_req,
    input logic        core_wr,
    input logic [13:0] core_addr,
    input logic [15:0] core_wdata,
    input logic [1:0]  ovl_page,
    input logic        core_ack,
    input logic [15:0] core_rdata,
    input logic        core_busy,
    input logic [1:0]  acc_target,
    input logic        ext_active,
    input logic        ext_rd,
    input logic        ext_wr,
    input logic [13:0] ext_addr,
    input logic [15:0] ext_wdata,
    input logic        ext_ready,
    input logic [15:0] ext_rdata
);
    // R5: a reserved-page lower-half request starts no external cycle
    a_r5_no_ext_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && !core_busy && !core_addr[13] && (ovl_page == 2'd0 || ovl_page == 2'd3)
        |=> !ext_active && core_ack && acc_target == 2'd0 && core_rdata == 16'h0);

    // R6: on-chip requests complete in the next cycle without a stall
    a_r6_onchip_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && !core_busy && core_addr[13] |=> core_ack && !core_busy);

    // R7: a waiting external cycle keeps its pins steady
    a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ext_active && !ext_ready |=> ext_active && $stable(ext_addr) && $stable(ext_rd) && $stable(ext_wr));

    // R8: ready ends the cycle and acknowledges with the external data
    a_r8_ready_completes: assert property (@(posedge clk) disable iff (!rst_n)
        ext_active && ext_ready |=> core_ack && !ext_active && core_rdata == $past(ext_rdata));

    // R3: an external cycle for page 1 drives the top address bit low
    a_r3_page1_low: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && !core_busy && !core_addr[13] && ovl_page == 2'd1 |=> ext_active && !ext_addr[13]);

    // R4: an external cycle for page 2 drives the top address bit high
    a_r4_page2_high: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && !core_busy && !core_addr[13] && ovl_page == 2'd2 |=> ext_active && ext_addr[13]);

    // R10: no acknowledge while an external cycle is still waiting
    a_r10_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ext_active && !ext_ready |=> !core_ack);

    // R7: the two strobes are never both high
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));
endmodule

bind dmo_decoder dmo_decoder_chk u_chk (.*);

// File: tb/sim_dmo_decoder.sv
module sim_dmo_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // Each entry: {addr[13:0], page[1:0], expected target[1:0], expected top bit}
    localparam logic [18:0] VEC [NVEC] = '{
        {14'h1FFF, 2'd1, 2'd3, 1'b0},
        {14'h2000, 2'd1, 2'd1, 1'b0},
        {14'h1FFF, 2'd2, 2'd3, 1'b1},
        {14'h0000, 2'd2, 2'd3, 1'b1},
        {14'h2000, 2'd2, 2'd1, 1'b0},
        {14'h3FDF, 2'd1, 2'd1, 1'b0},
        {14'h3FE0, 2'd2, 2'd2, 1'b0},
        {14'h3FFF, 2'd0, 2'd2, 1'b0},
        {14'h1FFF, 2'd0, 2'd0, 1'b0},
        {14'h0000, 2'd3, 2'd0, 1'b0},
        {14'h3FDF, 2'd0, 2'd1, 1'b0},
        {14'h0ABC, 2'd1, 2'd3, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0;
    logic        core_wr = 1'b0;
    logic [13:0] core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic [1:0]  ovl_page = '0;
    logic        core_ack;
    logic [15:0] core_rdata;
    logic        core_busy;
    logic [1:0]  acc_target;
    logic        ext_active;
    logic        ext_rd;
    logic        ext_wr;
    logic [13:0] ext_addr;
    logic [15:0] ext_wdata;
    logic        ext_ready = 1'b0;
    logic [15:0] ext_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Results of the last access.
    logic        r_ack;
    logic [1:0]  r_tgt;
    logic [15:0] r_rdata;
    logic        r_saw_ext;
    logic        r_a13;
    logic [12:0] r_low;
    logic        r_stable;
    logic        r_wrstb;

    dmo_decoder u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one access. The wait-state side answers after 'delay' waiting cycles.
    task automatic access(input logic [13:0] a, input logic [1:0] pg, input bit wr,
                          input logic [15:0] wd, input int delay, input logic [15:0] xrd);
        int n;
        logic [13:0] first;
        @(negedge clk);
        core_req = 1'b1; core_wr = wr; core_addr = a; core_wdata = wd; ovl_page = pg;
        @(negedge clk);
        core_req = 1'b0;
        r_saw_ext = 1'b0; r_stable = 1'b1; r_ack = 1'b0; r_wrstb = 1'b0;
        first = ext_addr;
        n = 0;
        while (!core_ack && n < 40) begin
            if (ext_active) begin
                r_saw_ext = 1'b1;
                r_a13 = ext_addr[13];
                r_low = ext_addr[12:0];
                r_wrstb = ext_wr;
                if (ext_addr != first) r_stable = 1'b0;
                if (n >= delay) begin ext_ready = 1'b1; ext_rdata = xrd; end
            end
            @(negedge clk);
            ext_ready = 1'b0;
            n++;
        end
        r_ack = core_ack;
        r_tgt = acc_target;
        r_rdata = core_rdata;
        @(negedge clk);
        chk(!core_ack, "R6 ack lasts one cycle", 32'(core_ack), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(core_ack == 0 && core_busy == 0 && ext_active == 0 && core_rdata == 0,
            "R11 reset outputs", {core_ack, core_busy, ext_active, core_rdata}, 32'd0);

        // Boundary table walk (R1 R2 R3 R4 R5)
        for (int i = 0; i < NVEC; i++) begin
            logic [13:0] va;
            logic [1:0]  vp, vt;
            logic        vh;
            {va, vp, vt, vh} = VEC[i];
            access(va, vp, 1'b0, 16'h0, 1, 16'h5A00 + 16'(i));
            chk(r_ack == 1'b1, "R6 access acknowledged", 32'(r_ack), 32'd1);
            chk(r_tgt == vt, "R1 R2 R3 R5 target code", 32'(r_tgt), 32'(vt));
            chk(r_saw_ext == (vt == 2'd3), "R5 external flag", 32'(r_saw_ext), 32'(vt == 2'd3));
            if (vt == 2'd3) begin
                chk(r_a13 == vh, "R3 R4 top external bit", 32'(r_a13), 32'(vh));
                chk(r_low == va[12:0], "R3 low address bits", 32'(r_low), 32'(va[12:0]));
                chk(r_rdata == 16'h5A00 + 16'(i), "R8 external read data", 32'(r_rdata), 32'(16'h5A00 + 16'(i)));
            end
            if (vt == 2'd0)
                chk(r_rdata == 16'h0, "R5 reserved read data", 32'(r_rdata), 32'd0);
        end

        // R1: RAM write then read back
        access(14'h2123, 2'd0, 1'b1, 16'hC0DE, 0, 16'h0);
        access(14'h2123, 2'd0, 1'b0, 16'h0, 0, 16'h0);
        chk(r_rdata == 16'hC0DE, "R1 RAM readback", 32'(r_rdata), 32'hC0DE);

        // R9: register reset value, then masking on even and odd indices
        access(14'h3FE4, 2'd0, 1'b0, 16'h0, 0, 16'h0);
        chk(r_rdata == 16'h0, "R9 register reset value", 32'(r_rdata), 32'd0);
        access(14'h3FE4, 2'd0, 1'b1, 16'hA5C3, 0, 16'h0);
        access(14'h3FE4, 2'd0, 1'b0, 16'h0, 0, 16'h0);
        chk(r_rdata == 16'hA5C3, "R9 even register full width", 32'(r_rdata), 32'hA5C3);
        access(14'h3FE5, 2'd0, 1'b1, 16'hFFFF, 0, 16'h0);
        access(14'h3FE5, 2'd0, 1'b0, 16'h0, 0, 16'h0);
        chk(r_rdata == 16'h00FF, "R9 odd register upper bits zero", 32'(r_rdata), 32'h00FF);

        // R5: a write to a reserved page is dropped. Page-1 read-back sees the bus, not a stored value.
        access(14'h0100, 2'd3, 1'b1, 16'h1234, 0, 16'h0);
        chk(r_saw_ext == 1'b0 && r_tgt == 2'd0, "R5 reserved write no strobe", 32'(r_saw_ext), 32'd0);

        // R4 R8: external write with a long wait
        access(14'h0042, 2'd2, 1'b1, 16'hBEEF, 5, 16'h0);
        chk(r_wrstb == 1'b1 && r_a13 == 1'b1, "R4 external write strobe and page bit",
            {r_wrstb, r_a13}, 32'd3);
        chk(r_stable == 1'b1, "R7 address stable while waiting", 32'(r_stable), 32'd1);

        // R7 R10: page flip and a stray request while an external cycle waits
        access(14'h2077, 2'd0, 1'b1, 16'h1111, 0, 16'h0);
        @(negedge clk);
        core_req = 1'b1; core_wr = 1'b0; core_addr = 14'h0055; ovl_page = 2'd2;
        @(negedge clk);
        core_req = 1'b0;
        chk(ext_active && ext_addr[13], "R4 concurrent cycle started", {ext_active, ext_addr[13]}, 32'd3);
        ovl_page = 2'd1;
        core_req = 1'b1; core_wr = 1'b1; core_addr = 14'h2077; core_wdata = 16'h2222;
        @(negedge clk);
        core_req = 1'b0;
        chk(ext_addr[13] == 1'b1, "R7 page change ignored during cycle", 32'(ext_addr[13]), 32'd1);
        chk(!core_ack, "R10 no ack for busy request", 32'(core_ack), 32'd0);
        @(negedge clk);
        chk(!core_ack && ext_active, "R7 still waiting", {core_ack, ext_active}, 32'd1);
        ext_ready = 1'b1; ext_rdata = 16'h7E57;
        @(negedge clk);
        ext_ready = 1'b0;
        chk(core_ack && core_rdata == 16'h7E57, "R8 ack after ready", 32'(core_rdata), 32'h7E57);
        @(negedge clk);
        chk(!core_ack, "R10 single acknowledge", 32'(core_ack), 32'd0);
        access(14'h2077, 2'd0, 1'b0, 16'h0, 0, 16'h0);
        chk(r_rdata == 16'h1111, "R10 busy write dropped", 32'(r_rdata), 32'h1111);

        // R11: reset in the middle of an external cycle
        @(negedge clk);
        core_req = 1'b1; core_wr = 1'b0; core_addr = 14'h0010; ovl_page = 2'd1;
        @(negedge clk);
        core_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!ext_active && !core_busy && !core_ack, "R11 reset clears cycle",
            {ext_active, core_busy, core_ack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule